// File: doc/BRIEF.md
# Serial Port Interrupt Controller with Receive Idle Timer

This block gathers the eight interrupt sources of a byte-stream serial port and presents them as separately maskable interrupt lines. Each source has a pending bit, an enable bit and a way for software to force it. The pending bits are fed by threshold comparisons on the transmit and receive buffer fill levels, by overflow event pulses, by a line-break condition and by a receive idle timer. Two sources, framing error and parity error, have no hardware cause and can only be raised by software.

The receive idle timer measures elapsed time in serial bit periods. The bit period comes from a 16-bit rate increment added into a fractional phase accumulator each clock. Sixteen accumulator carries make one bit period. The timer expires when unread bytes have sat in the receive buffer for a programmed number of bit periods. The surrounding register decoder supplies the write strobes and the configuration fields, and the buffers supply their fill levels and push/pop strobes.

Top module: `serial_irq_ctrl`

## Requirements
- R1: After reset all pending bits and all enable bits are 0. Each interrupt line is asserted exactly when its pending bit and its enable bit are both 1. The bit index of each source is fixed: 0 transmit threshold, 1 receive threshold, 2 transmit overflow, 3 receive overflow, 4 framing error, 5 line break, 6 receive idle timeout, 7 parity error.
- R2: A pending-clear write clears every pending bit whose data bit is 1 and leaves the others unchanged. A force write sets every pending bit whose data bit is 1. When a set and a clear land on the same bit in the same cycle, the set wins.
- R3: The receive threshold condition is `rx_level >= T`. The 3-bit code selects T as follows: 0 selects 1, 1 selects 4, 2 selects 8, 3 selects 16, and 4 selects 30. Codes 5 to 7 are reserved and behave as 30.
- R4: The transmit threshold condition is `tx_level < T`. The 2-bit code selects T as follows: 0 selects 1, 1 selects 4, 2 selects 8, and 3 selects 16.
- R5: Level conditions set their pending bits only on a false-to-true transition, and that transition is counted from a false state at reset. If software clears a pending bit while its condition stays true, the bit stays cleared. An overflow pulse sets its pending bit in the cycle it arrives.
- R6: A rising edge of the line-break input sets pending bit 5.
- R7: With the timer enabled, a non-empty receive buffer and no push or pop, pending bit 6 is set once floor(k·INC/2^20) reaches the programmed limit. Here k counts clocks after the last restart.
- R8: A receive push or pop restarts the idle timer from zero. An empty receive buffer holds the timer at zero. With the timer disabled, bit 6 is never set by hardware.
- R9: Pending bits 4 and 7 change to 1 only through a force write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_level_i | input | 6 | Transmit buffer fill level |
| rx_level_i | input | 6 | Receive buffer fill level |
| tx_ovf_i | input | 1 | Transmit overflow event pulse |
| rx_ovf_i | input | 1 | Receive overflow event pulse |
| line_break_i | input | 1 | Line-break condition (level) |
| rx_push_i | input | 1 | Byte written into receive buffer |
| rx_pop_i | input | 1 | Byte read from receive buffer |
| rx_thr_code_i | input | 3 | Receive threshold code |
| tx_thr_code_i | input | 2 | Transmit threshold code |
| rate_inc_i | input | 16 | Rate increment added per clock |
| idle_limit_i | input | 24 | Idle timeout in bit periods |
| idle_en_i | input | 1 | Idle timer enable |
| wr_data_i | input | 8 | Write data for the three register strobes |
| pend_clr_we_i | input | 1 | Clear pending bits where data is 1 |
| force_we_i | input | 1 | Set pending bits where data is 1 |
| mask_we_i | input | 1 | Load enable register from data |
| pending_o | output | 8 | Pending bits |
| mask_o | output | 8 | Enable bits |
| irq_o | output | 8 | Interrupt lines |

## Verification
The hardest situation to reach from the ports is the idle-timer expiry boundary. It sits roughly a hundred clocks after the last push or pop, and it only occurs when the rate accumulator, the sixteen-step sub-bit counter and the bit counter all line up. The bench uses a half-scale increment so that one bit period is exactly 32 clocks, and it samples just before and just after the computed expiry. A pop injected partway through the interval shows that expiry moves out by the full period. The threshold decoders are swept over every code and every fill level from 0 to 32. Before each level the bench drives the condition false and clears the bit, so that every sample sees a fresh edge.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

   localparam int unsigned NUM_IRQ = 8;

   localparam int unsigned IDX_TX_THR  = 0;
   localparam int unsigned IDX_RX_THR  = 1;
   localparam int unsigned IDX_TX_OVF  = 2;
   localparam int unsigned IDX_RX_OVF  = 3;
   localparam int unsigned IDX_FRAME   = 4;
   localparam int unsigned IDX_BREAK   = 5;
   localparam int unsigned IDX_IDLE    = 6;
   localparam int unsigned IDX_PARITY  = 7;

   // receive threshold in characters; reserved codes map to the top value
   function automatic int unsigned rx_thr_chars(input logic [2:0] code);
      case (code)
         3'd0:    return 1;
         3'd1:    return 4;
         3'd2:    return 8;
         3'd3:    return 16;
         default: return 30;
      endcase
   endfunction

   function automatic int unsigned tx_thr_chars(input logic [1:0] code);
      case (code)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/sirq_thr_decode.sv
module sirq_thr_decode #(
   parameter int unsigned LVL_W = 6
) (
   input  logic [2:0]       rx_code_i,
   input  logic [1:0]       tx_code_i,
   input  logic [LVL_W-1:0] rx_level_i,
   input  logic [LVL_W-1:0] tx_level_i,
   output logic             rx_cond_o,
   output logic             tx_cond_o
);
   import sirq_pkg::*;

   logic [LVL_W:0] rx_thr, tx_thr;

   always_comb begin
      rx_thr    = (LVL_W+1)'(rx_thr_chars(rx_code_i));
      tx_thr    = (LVL_W+1)'(tx_thr_chars(tx_code_i));
      rx_cond_o = {1'b0, rx_level_i} >= rx_thr;
      tx_cond_o = {1'b0, tx_level_i} <  tx_thr;
   end

endmodule

// File: rtl/sirq_idle_timer.sv
module sirq_idle_timer #(
   parameter int unsigned INC_W = 16,
   parameter int unsigned SUB_W = 4,
   parameter int unsigned VAL_W = 24
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [INC_W-1:0] inc_i,
   input  logic             nonempty_i,
   input  logic             restart_i,
   input  logic             en_i,
   input  logic [VAL_W-1:0] limit_i,
   output logic             expired_o
);
   localparam logic [VAL_W-1:0] CNT_MAX = '1;

   logic [INC_W-1:0] acc_q;
   logic [INC_W:0]   acc_sum;
   logic             carry;
   logic             bit_tick;
   logic [VAL_W-1:0] cnt_q;
   logic             hold;

   assign acc_sum = {1'b0, acc_q} + {1'b0, inc_i};
   assign carry   = acc_sum[INC_W];
   assign hold    = restart_i || !nonempty_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   acc_q <= '0;
      else if (hold) acc_q <= '0;
      else           acc_q <= acc_sum[INC_W-1:0];
   end

   generate
      if (SUB_W == 0) begin : g_no_sub
         assign bit_tick = carry;
      end else begin : g_sub
         logic [SUB_W-1:0] sub_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     sub_q <= '0;
            else if (hold)   sub_q <= '0;
            else if (carry)  sub_q <= sub_q + 1'b1;
         end
         assign bit_tick = carry && (sub_q == '1);
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            cnt_q <= '0;
      else if (hold)                          cnt_q <= '0;
      else if (bit_tick && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = en_i && nonempty_i && (cnt_q >= limit_i);

   assert_empty_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !nonempty_i |=> cnt_q == '0);
   assert_restart_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> cnt_q == '0);

endmodule

// File: rtl/sirq_pend_regs.sv
module sirq_pend_regs #(
   parameter int unsigned N = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] hw_set_i,
   input  logic [N-1:0] wdata_i,
   input  logic         clr_we_i,
   input  logic         force_we_i,
   input  logic         mask_we_i,
   output logic [N-1:0] pend_o,
   output logic [N-1:0] mask_o
);
   logic [N-1:0] pend_q, mask_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic set_b, clr_b;
         assign set_b = hw_set_i[i] || (force_we_i && wdata_i[i]);
         assign clr_b = clr_we_i && wdata_i[i];
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)    pend_q[i] <= 1'b0;
            else if (set_b) pend_q[i] <= 1'b1;
            else if (clr_b) pend_q[i] <= 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mask_q <= '0;
      else if (mask_we_i) mask_q <= wdata_i;
   end

   assign pend_o = pend_q;
   assign mask_o = mask_q;

   assert_clear_works_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_we_i && !force_we_i && ((wdata_i & hw_set_i) == '0))
      |=> ((pend_q & $past(wdata_i)) == '0));
   assert_force_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_we_i |=> ((pend_q & $past(wdata_i)) == $past(wdata_i)));

endmodule

// File: rtl/serial_irq_ctrl.sv
module serial_irq_ctrl #(
   parameter int unsigned FIFO_DEPTH = 32,
   parameter int unsigned INC_W      = 16,
   parameter int unsigned SUB_W      = 4,
   parameter int unsigned VAL_W      = 24,
   parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [LVL_W-1:0] tx_level_i,
   input  logic [LVL_W-1:0] rx_level_i,
   input  logic             tx_ovf_i,
   input  logic             rx_ovf_i,
   input  logic             line_break_i,
   input  logic             rx_push_i,
   input  logic             rx_pop_i,
   input  logic [2:0]       rx_thr_code_i,
   input  logic [1:0]       tx_thr_code_i,
   input  logic [INC_W-1:0] rate_inc_i,
   input  logic [VAL_W-1:0] idle_limit_i,
   input  logic             idle_en_i,
   input  logic [7:0]       wr_data_i,
   input  logic             pend_clr_we_i,
   input  logic             force_we_i,
   input  logic             mask_we_i,
   output logic [7:0]       pending_o,
   output logic [7:0]       mask_o,
   output logic [7:0]       irq_o
);
   import sirq_pkg::*;

   generate
      if (FIFO_DEPTH < 30) begin : g_bad_depth
         $error("FIFO_DEPTH must hold the largest receive threshold");
      end
      if (INC_W < 2) begin : g_bad_inc
         $error("INC_W too small");
      end
   endgenerate

   logic rx_cond, tx_cond, idle_cond;
   logic rx_prev_q, tx_prev_q, brk_prev_q, idle_prev_q;
   logic [NUM_IRQ-1:0] hw_set;

   sirq_thr_decode #(.LVL_W(LVL_W)) u_thr (
      .rx_code_i  (rx_thr_code_i),
      .tx_code_i  (tx_thr_code_i),
      .rx_level_i (rx_level_i),
      .tx_level_i (tx_level_i),
      .rx_cond_o  (rx_cond),
      .tx_cond_o  (tx_cond)
   );

   sirq_idle_timer #(.INC_W(INC_W), .SUB_W(SUB_W), .VAL_W(VAL_W)) u_idle (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .inc_i      (rate_inc_i),
      .nonempty_i (rx_level_i != '0),
      .restart_i  (rx_push_i || rx_pop_i),
      .en_i       (idle_en_i),
      .limit_i    (idle_limit_i),
      .expired_o  (idle_cond)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rx_prev_q   <= 1'b0;
         tx_prev_q   <= 1'b0;
         brk_prev_q  <= 1'b0;
         idle_prev_q <= 1'b0;
      end else begin
         rx_prev_q   <= rx_cond;
         tx_prev_q   <= tx_cond;
         brk_prev_q  <= line_break_i;
         idle_prev_q <= idle_cond;
      end
   end

   always_comb begin
      hw_set             = '0;
      hw_set[IDX_TX_THR] = tx_cond && !tx_prev_q;
      hw_set[IDX_RX_THR] = rx_cond && !rx_prev_q;
      hw_set[IDX_TX_OVF] = tx_ovf_i;
      hw_set[IDX_RX_OVF] = rx_ovf_i;
      hw_set[IDX_BREAK]  = line_break_i && !brk_prev_q;
      hw_set[IDX_IDLE]   = idle_cond && !idle_prev_q;
   end

   sirq_pend_regs #(.N(NUM_IRQ)) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hw_set_i   (hw_set),
      .wdata_i    (wr_data_i),
      .clr_we_i   (pend_clr_we_i),
      .force_we_i (force_we_i),
      .mask_we_i  (mask_we_i),
      .pend_o     (pending_o),
      .mask_o     (mask_o)
   );

   assign irq_o = pending_o & mask_o;

   assert_frame_sw_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pending_o[IDX_FRAME]) |-> $past(force_we_i && wr_data_i[IDX_FRAME]));
   assert_parity_sw_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pending_o[IDX_PARITY]) |-> $past(force_we_i && wr_data_i[IDX_PARITY]));
   assert_idle_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!idle_en_i && !(force_we_i && wr_data_i[IDX_IDLE])) |=> !$rose(pending_o[IDX_IDLE]));

endmodule

// File: tb/serial_irq_ctrl_tb.sv
module serial_irq_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] tx_level = '0, rx_level = '0;
   logic       tx_ovf = 0, rx_ovf = 0, brk = 0, push = 0, pop = 0;
   logic [2:0] rx_code = '0;
   logic [1:0] tx_code = '0;
   logic [15:0] inc = 16'h8000;
   logic [23:0] limit = 24'd3;
   logic       idle_en = 0;
   logic [7:0] wdata = '0;
   logic       clr_we = 0, force_we = 0, mask_we = 0;
   logic [7:0] pend, msk, irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   serial_irq_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .tx_level_i(tx_level), .rx_level_i(rx_level),
      .tx_ovf_i(tx_ovf), .rx_ovf_i(rx_ovf), .line_break_i(brk),
      .rx_push_i(push), .rx_pop_i(pop),
      .rx_thr_code_i(rx_code), .tx_thr_code_i(tx_code),
      .rate_inc_i(inc), .idle_limit_i(limit), .idle_en_i(idle_en),
      .wr_data_i(wdata), .pend_clr_we_i(clr_we), .force_we_i(force_we), .mask_we_i(mask_we),
      .pending_o(pend), .mask_o(msk), .irq_o(irq)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_clear(input logic [7:0] d);
      @(negedge clk); wdata = d; clr_we = 1;
      @(negedge clk); clr_we = 0;
   endtask

   task automatic do_force(input logic [7:0] d);
      @(negedge clk); wdata = d; force_we = 1;
      @(negedge clk); force_we = 0;
   endtask

   function automatic int rx_thr(input int code);
      if (code == 0) return 1;
      if (code < 4)  return 1 << (code + 1);
      return 30;
   endfunction

   function automatic int tx_thr(input int code);
      return (code == 0) ? 1 : (1 << (code + 1));
   endfunction

   initial begin
      int wd = 0;
      while (wd < 150000) begin @(posedge clk); wd++; end
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      tx_level = 6'd32;
      // reset state
      #5;
      check(pend == 8'h00 && msk == 8'h00, "R1 reset", {msk, pend}, 0);
      wait_n(3);
      rst_n = 1;
      wait_n(2);
      check(pend == 8'h00 && irq == 8'h00, "R1 after reset idle", pend, 0);

      // enable and gating
      @(negedge clk); wdata = 8'hA5; mask_we = 1;
      @(negedge clk); mask_we = 0;
      check(msk == 8'hA5, "R1 mask load", msk, 8'hA5);
      do_force(8'hFF);
      check(pend == 8'hFF, "R2 force all", pend, 8'hFF);
      check(irq == 8'hA5, "R1 gating", irq, 8'hA5);
      do_clear(8'h0F);
      check(pend == 8'hF0, "R2 partial clear", pend, 8'hF0);
      check(irq == 8'hA0, "R1 gating after clear", irq, 8'hA0);
      do_clear(8'hFF);
      check(pend == 8'h00, "R2 clear all", pend, 0);

      // set wins over clear
      @(negedge clk); wdata = 8'h04; clr_we = 1; tx_ovf = 1;
      @(negedge clk); clr_we = 0; tx_ovf = 0;
      check(pend[2] == 1'b1, "R2 set beats clear", pend, 8'h04);
      @(negedge clk); rx_ovf = 1;
      @(negedge clk); rx_ovf = 0;
      check(pend[3] == 1'b1, "R5 rx overflow pulse", pend, 8'h0C);
      do_clear(8'hFF);

      // line break edge
      @(negedge clk); brk = 1;
      wait_n(2);
      check(pend == 8'h20, "R6 break edge", pend, 8'h20);
      do_clear(8'h20);
      wait_n(3);
      check(pend[5] == 1'b0, "R5 held level does not re-set", pend, 0);
      brk = 0;

      // frame/parity only by force
      wait_n(3);
      check(pend[4] == 0 && pend[7] == 0, "R9 no hw frame/parity", pend, 0);
      do_force(8'h90);
      check(pend[4] == 1 && pend[7] == 1, "R9 force frame/parity", pend, 8'h90);
      do_clear(8'hFF);

      // receive threshold sweep
      for (int c = 0; c < 8; c++) begin
         rx_code = 3'(c);
         for (int lv = 0; lv <= 32; lv++) begin
            @(negedge clk); rx_level = 0;
            wait_n(1);
            do_clear(8'h02);
            rx_level = 6'(lv);
            wait_n(2);
            check(pend[1] == (lv >= rx_thr(c)), $sformatf("R3 code %0d level %0d", c, lv),
                  pend[1], (lv >= rx_thr(c)));
         end
      end
      rx_level = 6'd20; rx_code = 3'd0;
      wait_n(2);
      do_clear(8'h02);
      wait_n(3);
      check(pend[1] == 0, "R5 cleared while condition true", pend, 0);
      rx_level = 0;

      // transmit threshold sweep
      for (int c = 0; c < 4; c++) begin
         tx_code = 2'(c);
         for (int lv = 0; lv <= 32; lv++) begin
            @(negedge clk); tx_level = 6'd32;
            wait_n(1);
            do_clear(8'h01);
            tx_level = 6'(lv);
            wait_n(2);
            check(pend[0] == (lv < tx_thr(c)), $sformatf("R4 code %0d level %0d", c, lv),
                  pend[0], (lv < tx_thr(c)));
         end
      end
      tx_level = 6'd32;
      do_clear(8'hFF);

      // idle timer: 32 clocks per bit, limit 3 -> expiry after 97 posedges
      idle_en = 1; limit = 24'd3; inc = 16'h8000;
      @(negedge clk); rx_level = 1; push = 1;
      @(negedge clk); push = 0;
      wait_n(93);
      check(pend[6] == 0, "R7 before expiry", pend, 0);
      wait_n(6);
      check(pend[6] == 1, "R7 after expiry", pend, 8'h40);
      rx_level = 0;
      wait_n(2);
      do_clear(8'hFF);

      // pop restarts
      @(negedge clk); rx_level = 1; push = 1;
      @(negedge clk); push = 0;
      wait_n(58);
      @(negedge clk); pop = 1;
      @(negedge clk); pop = 0;
      wait_n(78);
      check(pend[6] == 0, "R8 pop restarts timer", pend, 0);
      wait_n(25);
      check(pend[6] == 1, "R8 expiry after restart", pend, 8'h40);
      rx_level = 0;
      wait_n(2);
      do_clear(8'hFF);

      // empty buffer holds timer
      wait_n(200);
      check(pend[6] == 0, "R8 empty holds timer", pend, 0);
      // disabled timer
      idle_en = 0;
      @(negedge clk); rx_level = 1; push = 1;
      @(negedge clk); push = 0;
      wait_n(200);
      check(pend[6] == 0, "R8 disabled timer", pend, 0);
      rx_level = 0;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule